// File: doc/BRIEF.md
# Best-Fit SPI Bit-Rate Divider Search

This block finds the divider setting for a serial peripheral clock. Given a system clock frequency, a requested bit rate and a permission flag for double-rate operation, it steps through a small prescaler table and a larger scaler table. It returns the pair of table indices, and the double-rate bit, that give the fastest bit rate that is still not above the request. When the request is below everything the tables can reach, it flags an error and returns the slowest setting.

A second table set, picked with a mode input, turns the same engine into a calculator for chip-select timing delays. In that mode a delay is expressed as an equivalent rate. The engine needs no divider. Each candidate is judged by cross-multiplying, one candidate per clock. A one-cycle start and a one-cycle done pulse frame each search. The result stays on the outputs until a later search finishes.

Top module: `baud_fit_search`

## Requirements
- R1: Rate tables, index order fixed: prescaler index 0..3 = 2, 3, 5, 7; scaler index 0..15 = 2, 4, 6, 8, then 16, 32, ... 32768 (scaler index i >= 4 means 2^i).
- R2: A candidate rate is clk_hz × (1 + dbl) / (prescaler × scaler), an exact rational value. A candidate fits when clk_hz × (1 + dbl) <= target_hz × prescaler × scaler.
- R3: The search visits prescaler indices 0..2 in the outer loop and scaler indices 0..14 in the inner loop. A fitting candidate replaces the stored best only when its rate is strictly higher, so among equal rates the first one visited is kept.
- R4: When a candidate's rate equals target_hz exactly, the search ends on that candidate and returns it.
- R5: dbl_rate is used only when 4 × target_hz > clk_hz, allow_double = 1 and delay_mode = 0. A target of exactly clk_hz/4 does not use it.
- R6: When no candidate fits, fit_error = 1, fit_valid = 0, pre_idx = 3, scl_idx = 15 and dbl_rate = 0.
- R7: With delay_mode = 1 the tables are: prescaler 1, 3, 5, 7; scaler 2^(i+1) for index i (2 up to 65536). Double rate is never used in this mode.
- R8: One candidate is judged per clock. busy rises in the cycle after an accepted start. done rises in the cycle after the edge that judges the n-th candidate, where n is the number of candidates visited (45 for a full scan).
- R9: start is ignored while busy. A second start during a scan changes neither the result nor the finish time.
- R10: done is high for exactly one cycle. fit_valid, fit_error, pre_idx, scl_idx and dbl_rate change only in the cycle done is high, and otherwise hold.
- R11: After reset, busy, done, fit_valid, fit_error, pre_idx, scl_idx and dbl_rate are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a search; sampled when idle |
| clk_hz | input | 32 | System clock frequency |
| target_hz | input | 32 | Requested rate (or delay as a rate) |
| allow_double | input | 1 | Permits double-rate operation |
| delay_mode | input | 1 | 1 selects the delay tables |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| fit_valid | output | 1 | A fitting setting was found |
| fit_error | output | 1 | No setting fits; slowest returned |
| pre_idx | output | 2 | Chosen prescaler index |
| scl_idx | output | 4 | Chosen scaler index |
| dbl_rate | output | 1 | Chosen double-rate bit |

## Verification
A search that ends on an exact match at prescaler index p and scaler index s finishes after 15p + s + 1 clock edges. Any other search takes 45 edges. The bench counts edges from the one that accepts start, samples done on each falling edge, and compares that count with the expected candidate count. It compares the result fields in the cycle done is high. It then checks, one cycle later, that done has dropped and the results hold. A start pulse in the middle of a scan must leave both the finish edge and the result unchanged.

// File: rtl/baud_fit_pkg.sv
package baud_fit_pkg;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_SCAN = 1'b1
    } phase_e;

    // Prescaler factor for a table index; delay tables start at 1.
    function automatic int unsigned pre_factor(input logic dly, input int unsigned idx);
        int unsigned f;
        case (idx)
            0:       f = dly ? 32'd1 : 32'd2;
            1:       f = 32'd3;
            2:       f = 32'd5;
            default: f = 32'd7;
        endcase
        return f;
    endfunction

    // Scaler factor for a table index; rate tables are linear for the first four.
    function automatic int unsigned scl_factor(input logic dly, input int unsigned idx);
        int unsigned f;
        if (dly)
            f = 32'd2 << idx;
        else if (idx < 4)
            f = 2 * (idx + 1);
        else
            f = 32'd1 << idx;
        return f;
    endfunction

endpackage

// File: rtl/baud_fit_table.sv
module baud_fit_table
    import baud_fit_pkg::*;
#(
    parameter int PRE_IW = 2,
    parameter int SCL_IW = 4,
    parameter int FACT_W = 20
) (
    input  logic              dly,
    input  logic [PRE_IW-1:0] p_idx,
    input  logic [SCL_IW-1:0] s_idx,
    output logic [FACT_W-1:0] pre_f,
    output logic [FACT_W-1:0] scl_f
);

    int unsigned pre_raw;
    int unsigned scl_raw;

    always_comb begin
        pre_raw = pre_factor(dly, 32'(p_idx));
        scl_raw = scl_factor(dly, 32'(s_idx));
        pre_f   = FACT_W'(pre_raw);
        scl_f   = FACT_W'(scl_raw);
    end

endmodule

// File: rtl/baud_fit_judge.sv
module baud_fit_judge #(
    parameter int FREQ_W = 32,
    parameter int FACT_W = 20
) (
    input  logic [FREQ_W-1:0]   clk_hz,
    input  logic [FREQ_W-1:0]   tgt_hz,
    input  logic                dbl,
    input  logic [FACT_W-1:0]   pre_f,
    input  logic [FACT_W-1:0]   scl_f,
    input  logic                have_best,
    input  logic [2*FACT_W-1:0] best_den,
    output logic [2*FACT_W-1:0] den,
    output logic                fits,
    output logic                exact,
    output logic                better
);

    localparam int DEN_W  = 2 * FACT_W;
    localparam int PROD_W = FREQ_W + DEN_W + 1;

    logic [PROD_W-1:0] num;
    logic [PROD_W-1:0] lim;

    // Rate comparison by cross-multiplication: num/den <= tgt  <=>  num <= tgt*den.
    always_comb begin
        den    = DEN_W'(pre_f) * DEN_W'(scl_f);
        num    = PROD_W'(clk_hz) << dbl;
        lim    = PROD_W'(tgt_hz) * PROD_W'(den);
        fits   = (num <= lim);
        exact  = (num == lim);
        // Same numerator for every candidate: higher rate means smaller denominator.
        better = fits && (!have_best || (den < best_den));
    end

endmodule

// File: rtl/baud_fit_fsm.sv
module baud_fit_fsm
    import baud_fit_pkg::*;
#(
    parameter int FREQ_W = 32,
    parameter int PRE_N  = 4,
    parameter int SCL_N  = 16,
    parameter int FACT_W = 20
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic [FREQ_W-1:0]         clk_hz,
    input  logic [FREQ_W-1:0]         target_hz,
    input  logic                      allow_double,
    input  logic                      delay_mode,
    input  logic [2*FACT_W-1:0]       cand_den,
    input  logic                      cand_fits,
    input  logic                      cand_exact,
    input  logic                      cand_better,
    output logic [$clog2(PRE_N)-1:0]  cur_p,
    output logic [$clog2(SCL_N)-1:0]  cur_s,
    output logic [FREQ_W-1:0]         held_clk,
    output logic [FREQ_W-1:0]         held_tgt,
    output logic                      held_dbl,
    output logic                      held_dly,
    output logic                      have_best,
    output logic [2*FACT_W-1:0]       best_den,
    output logic                      busy,
    output logic                      done,
    output logic                      fit_valid,
    output logic                      fit_error,
    output logic [$clog2(PRE_N)-1:0]  pre_idx,
    output logic [$clog2(SCL_N)-1:0]  scl_idx,
    output logic                      dbl_rate
);

    localparam int PRE_IW   = $clog2(PRE_N);
    localparam int SCL_IW   = $clog2(SCL_N);
    localparam int DEN_W    = 2 * FACT_W;
    // The last table entry of each kind is the fallback, never scanned.
    localparam logic [PRE_IW-1:0] P_LAST = PRE_IW'(PRE_N - 2);
    localparam logic [SCL_IW-1:0] S_LAST = SCL_IW'(SCL_N - 2);
    localparam logic [PRE_IW-1:0] P_SLOW = PRE_IW'(PRE_N - 1);
    localparam logic [SCL_IW-1:0] S_SLOW = SCL_IW'(SCL_N - 1);

    typedef struct packed {
        phase_e              phase;
        logic [PRE_IW-1:0]   p_idx;
        logic [SCL_IW-1:0]   s_idx;
        logic [FREQ_W-1:0]   clk_v;
        logic [FREQ_W-1:0]   tgt_v;
        logic                dbl_v;
        logic                dly_v;
        logic                have;
        logic [DEN_W-1:0]    best_den;
        logic [PRE_IW-1:0]   best_p;
        logic [SCL_IW-1:0]   best_s;
        logic                done;
        logic                valid;
        logic                error;
        logic [PRE_IW-1:0]   out_p;
        logic [SCL_IW-1:0]   out_s;
        logic                out_dbl;
    } fsm_t;

    fsm_t st_d, st_q;

    logic                     last_cand;
    logic                     want_dbl;
    logic [FREQ_W+1:0]        tgt_x4;
    logic [FREQ_W+1:0]        clk_ext;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;

        tgt_x4    = {target_hz, 2'b00};
        clk_ext   = {2'b00, clk_hz};
        want_dbl  = allow_double && !delay_mode && (tgt_x4 > clk_ext);
        last_cand = (st_q.p_idx == P_LAST) && (st_q.s_idx == S_LAST);

        case (st_q.phase)
            PH_IDLE: begin
                if (start) begin
                    st_d.phase    = PH_SCAN;
                    st_d.p_idx    = '0;
                    st_d.s_idx    = '0;
                    st_d.clk_v    = clk_hz;
                    st_d.tgt_v    = target_hz;
                    st_d.dly_v    = delay_mode;
                    st_d.dbl_v    = want_dbl;
                    st_d.have     = 1'b0;
                    st_d.best_den = '0;
                    st_d.best_p   = '0;
                    st_d.best_s   = '0;
                end
            end
            PH_SCAN: begin
                if (cand_better) begin
                    st_d.have     = 1'b1;
                    st_d.best_den = cand_den;
                    st_d.best_p   = st_q.p_idx;
                    st_d.best_s   = st_q.s_idx;
                end
                if (cand_exact) begin
                    st_d.phase   = PH_IDLE;
                    st_d.done    = 1'b1;
                    st_d.valid   = 1'b1;
                    st_d.error   = 1'b0;
                    st_d.out_p   = st_q.p_idx;
                    st_d.out_s   = st_q.s_idx;
                    st_d.out_dbl = st_q.dbl_v;
                end else if (last_cand) begin
                    st_d.phase = PH_IDLE;
                    st_d.done  = 1'b1;
                    if (cand_better) begin
                        st_d.valid   = 1'b1;
                        st_d.error   = 1'b0;
                        st_d.out_p   = st_q.p_idx;
                        st_d.out_s   = st_q.s_idx;
                        st_d.out_dbl = st_q.dbl_v;
                    end else if (st_q.have) begin
                        st_d.valid   = 1'b1;
                        st_d.error   = 1'b0;
                        st_d.out_p   = st_q.best_p;
                        st_d.out_s   = st_q.best_s;
                        st_d.out_dbl = st_q.dbl_v;
                    end else begin
                        st_d.valid   = 1'b0;
                        st_d.error   = 1'b1;
                        st_d.out_p   = P_SLOW;
                        st_d.out_s   = S_SLOW;
                        st_d.out_dbl = 1'b0;
                    end
                end else if (st_q.s_idx == S_LAST) begin
                    st_d.s_idx = '0;
                    st_d.p_idx = st_q.p_idx + 1'b1;
                end else begin
                    st_d.s_idx = st_q.s_idx + 1'b1;
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Candidate-side view (unused by cand_fits here; it is folded into cand_better).
    logic unused_fits;
    assign unused_fits = cand_fits;

    assign cur_p     = st_q.p_idx;
    assign cur_s     = st_q.s_idx;
    assign held_clk  = st_q.clk_v;
    assign held_tgt  = st_q.tgt_v;
    assign held_dbl  = st_q.dbl_v;
    assign held_dly  = st_q.dly_v;
    assign have_best = st_q.have;
    assign best_den  = st_q.best_den;
    assign busy      = (st_q.phase == PH_SCAN);
    assign done      = st_q.done;
    assign fit_valid = st_q.valid;
    assign fit_error = st_q.error;
    assign pre_idx   = st_q.out_p;
    assign scl_idx   = st_q.out_s;
    assign dbl_rate  = st_q.out_dbl;

endmodule

// File: rtl/baud_fit_search.sv
module baud_fit_search #(
    parameter int FREQ_W = 32,
    parameter int PRE_N  = 4,
    parameter int SCL_N  = 16,
    parameter int FACT_W = 20
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic [FREQ_W-1:0]         clk_hz,
    input  logic [FREQ_W-1:0]         target_hz,
    input  logic                      allow_double,
    input  logic                      delay_mode,
    output logic                      busy,
    output logic                      done,
    output logic                      fit_valid,
    output logic                      fit_error,
    output logic [$clog2(PRE_N)-1:0]  pre_idx,
    output logic [$clog2(SCL_N)-1:0]  scl_idx,
    output logic                      dbl_rate
);

    localparam int PRE_IW = $clog2(PRE_N);
    localparam int SCL_IW = $clog2(SCL_N);
    localparam int DEN_W  = 2 * FACT_W;

    logic [PRE_IW-1:0] cur_p;
    logic [SCL_IW-1:0] cur_s;
    logic [FREQ_W-1:0] held_clk;
    logic [FREQ_W-1:0] held_tgt;
    logic              held_dbl;
    logic              held_dly;
    logic              have_best;
    logic [DEN_W-1:0]  best_den;
    logic [FACT_W-1:0] pre_f;
    logic [FACT_W-1:0] scl_f;
    logic [DEN_W-1:0]  cand_den;
    logic              cand_fits;
    logic              cand_exact;
    logic              cand_better;
    logic              scan_exact;
    logic              scan_better;

    baud_fit_table #(
        .PRE_IW (PRE_IW),
        .SCL_IW (SCL_IW),
        .FACT_W (FACT_W)
    ) u_table (
        .dly   (held_dly),
        .p_idx (cur_p),
        .s_idx (cur_s),
        .pre_f (pre_f),
        .scl_f (scl_f)
    );

    baud_fit_judge #(
        .FREQ_W (FREQ_W),
        .FACT_W (FACT_W)
    ) u_judge (
        .clk_hz    (held_clk),
        .tgt_hz    (held_tgt),
        .dbl       (held_dbl),
        .pre_f     (pre_f),
        .scl_f     (scl_f),
        .have_best (have_best),
        .best_den  (best_den),
        .den       (cand_den),
        .fits      (cand_fits),
        .exact     (cand_exact),
        .better    (cand_better)
    );

    // Judgements only matter while scanning; keep them quiet when idle.
    assign scan_exact  = busy && cand_exact;
    assign scan_better = busy && cand_better;

    baud_fit_fsm #(
        .FREQ_W (FREQ_W),
        .PRE_N  (PRE_N),
        .SCL_N  (SCL_N),
        .FACT_W (FACT_W)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .clk_hz       (clk_hz),
        .target_hz    (target_hz),
        .allow_double (allow_double),
        .delay_mode   (delay_mode),
        .cand_den     (cand_den),
        .cand_fits    (cand_fits),
        .cand_exact   (scan_exact),
        .cand_better  (scan_better),
        .cur_p        (cur_p),
        .cur_s        (cur_s),
        .held_clk     (held_clk),
        .held_tgt     (held_tgt),
        .held_dbl     (held_dbl),
        .held_dly     (held_dly),
        .have_best    (have_best),
        .best_den     (best_den),
        .busy         (busy),
        .done         (done),
        .fit_valid    (fit_valid),
        .fit_error    (fit_error),
        .pre_idx      (pre_idx),
        .scl_idx      (scl_idx),
        .dbl_rate     (dbl_rate)
    );

endmodule

// File: rtl/baud_fit_search_chk.sv
module baud_fit_search_chk #(
    parameter int FREQ_W = 32,
    parameter int PRE_N  = 4,
    parameter int SCL_N  = 16
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      start,
    input logic                      allow_double,
    input logic                      delay_mode,
    input logic                      busy,
    input logic                      done,
    input logic                      fit_valid,
    input logic                      fit_error,
    input logic [$clog2(PRE_N)-1:0]  pre_idx,
    input logic [$clog2(SCL_N)-1:0]  scl_idx,
    input logic                      dbl_rate
);

    localparam int SCAN_MAX = (PRE_N - 1) * (SCL_N - 1);
    localparam int CNT_W    = $clog2(SCAN_MAX + 1) + 1;

    logic             allow_seen;
    logic             dly_seen;
    logic [CNT_W-1:0] scan_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            allow_seen <= 1'b0;
            dly_seen   <= 1'b0;
            scan_cnt   <= '0;
        end else if (start && !busy) begin
            allow_seen <= allow_double;
            dly_seen   <= delay_mode;
            scan_cnt   <= '0;
        end else if (busy) begin
            scan_cnt   <= scan_cnt + 1'b1;
        end
    end

    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r10_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable({fit_valid, fit_error, pre_idx, scl_idx, dbl_rate}));

    a_r6_slowest_on_error: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fit_error) |-> (!fit_valid && !dbl_rate
            && pre_idx == ($clog2(PRE_N))'(PRE_N - 1)
            && scl_idx == ($clog2(SCL_N))'(SCL_N - 1)));

    a_r3_scanned_range: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fit_valid) |-> (!fit_error
            && 32'(pre_idx) <= PRE_N - 2 && 32'(scl_idx) <= SCL_N - 2));

    a_r5_double_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (done && dbl_rate) |-> (allow_seen && !dly_seen));

    a_r8_busy_follows_start: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    a_r8_scan_bound: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (32'(scan_cnt) < SCAN_MAX));

    a_r9_scan_continues: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (busy || done));

endmodule

bind baud_fit_search baud_fit_search_chk #(
    .FREQ_W (FREQ_W),
    .PRE_N  (PRE_N),
    .SCL_N  (SCL_N)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .allow_double (allow_double),
    .delay_mode   (delay_mode),
    .busy         (busy),
    .done         (done),
    .fit_valid    (fit_valid),
    .fit_error    (fit_error),
    .pre_idx      (pre_idx),
    .scl_idx      (scl_idx),
    .dbl_rate     (dbl_rate)
);

// File: tb/baud_fit_search_bench.sv
module baud_fit_search_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] clk_hz = '0;
    logic [31:0] target_hz = '0;
    logic        allow_double = 1'b0;
    logic        delay_mode = 1'b0;
    logic        busy, done, fit_valid, fit_error, dbl_rate;
    logic [1:0]  pre_idx;
    logic [3:0]  scl_idx;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    baud_fit_search u_baud_fit_search (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .clk_hz       (clk_hz),
        .target_hz    (target_hz),
        .allow_double (allow_double),
        .delay_mode   (delay_mode),
        .busy         (busy),
        .done         (done),
        .fit_valid    (fit_valid),
        .fit_error    (fit_error),
        .pre_idx      (pre_idx),
        .scl_idx      (scl_idx),
        .dbl_rate     (dbl_rate)
    );

    localparam int NV = 10;
    localparam logic [31:0] V_CLK [NV] = '{32'd119, 32'd48_000_000, 32'd100_000_000,
        32'd100_000_000, 32'd100_000_000, 32'd100_000_000, 32'd100_000_000,
        32'd100_000_000, 32'd100_000_000, 32'd81_920_000};
    localparam logic [31:0] V_TGT [NV] = '{32'd10, 32'd1_000_000, 32'd40_000_000,
        32'd40_000_000, 32'd1, 32'd30_000_000, 32'd25_000_000,
        32'd25_000_000, 32'd25_000_001, 32'd1000};
    localparam logic V_ALW [NV] = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0};
    localparam logic V_DLY [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0};
    localparam logic V_ERR [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0};
    localparam logic [1:0] V_P [NV] = '{2'd0, 2'd1, 2'd1, 2'd0, 2'd3, 2'd0, 2'd0, 2'd0, 2'd0, 2'd2};
    localparam logic [3:0] V_S [NV] = '{4'd2, 4'd4, 4'd0, 4'd0, 4'd15, 4'd1, 4'd1, 4'd0, 4'd1, 4'd14};
    localparam logic V_DBL [NV] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0};
    localparam int V_N [NV] = '{45, 20, 45, 45, 45, 45, 2, 1, 45, 45};
    localparam string V_REQ [NV] = '{"R3", "R4", "R5", "R2", "R6", "R7", "R7", "R5", "R5", "R1"};

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic launch(input logic [31:0] c, input logic [31:0] t,
                          input logic a, input logic d);
        @(negedge clk);
        clk_hz = c; target_hz = t; allow_double = a; delay_mode = d; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(output int n);
        n = 0;
        while (!done && n < 200) begin
            @(posedge clk);
            n++;
            @(negedge clk);
        end
    endtask

    task automatic check_result(input string req, input logic e, input logic [1:0] p,
                                input logic [3:0] s, input logic d);
        check(req, "fit_error", 64'(fit_error), 64'(e));
        check(req, "fit_valid", 64'(fit_valid), 64'(!e));
        check(req, "pre_idx", 64'(pre_idx), 64'(p));
        check(req, "scl_idx", 64'(scl_idx), 64'(s));
        check(req, "dbl_rate", 64'(dbl_rate), 64'(d));
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R8 watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int n;
        logic [1:0] hp;
        logic [3:0] hs;

        // R11: reset state
        repeat (3) @(negedge clk);
        check("R11", "busy", 64'(busy), 64'd0);
        check("R11", "done", 64'(done), 64'd0);
        check("R11", "valid/error", 64'({fit_valid, fit_error}), 64'd0);
        check("R11", "pre/scl/dbl", 64'({pre_idx, scl_idx, dbl_rate}), 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            launch(V_CLK[i], V_TGT[i], V_ALW[i], V_DLY[i]);
            check("R8", "busy after start", 64'(busy), 64'd1);
            wait_done(n);
            check("R8", "latency", 64'(n), 64'(V_N[i]));
            check_result(V_REQ[i], V_ERR[i], V_P[i], V_S[i], V_DBL[i]);
            hp = pre_idx; hs = scl_idx;
            @(negedge clk);
            check("R10", "done one cycle", 64'(done), 64'd0);
            check("R10", "result held", 64'({pre_idx, scl_idx}), 64'({hp, hs}));
            check("R8", "idle after done", 64'(busy), 64'd0);
        end

        // R9: a second start mid-scan is ignored
        launch(32'd100_000_000, 32'd40_000_000, 1'b1, 1'b0);
        n = 0;
        while (!done && n < 200) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (n == 5) begin
                clk_hz = 32'd100_000_000; target_hz = 32'd1;
                allow_double = 1'b0; delay_mode = 1'b1; start = 1'b1;
            end else if (n == 6) begin
                start = 1'b0;
                check("R9", "busy through second start", 64'(busy), 64'd1);
            end
        end
        check("R9", "latency unchanged", 64'(n), 64'd45);
        check_result("R9", 1'b0, 2'd1, 4'd0, 1'b1);

        // R10: outputs hold while inputs move without start
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            target_hz = 32'(k * 7 + 3);
            delay_mode = k[0];
        end
        check("R10", "no done without start", 64'(done), 64'd0);
        check_result("R10", 1'b0, 2'd1, 4'd0, 1'b1);

        // R6 in delay mode: unreachable target
        launch(32'd1_000_000_000, 32'd1, 1'b1, 1'b1);
        wait_done(n);
        check("R6", "latency", 64'(n), 64'd45);
        check_result("R6", 1'b1, 2'd3, 4'd15, 1'b0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule